// File: doc/BRIEF.md
# Keypad One-Shot Press Registration

This block sits between a matrix keypad scanner and whatever consumes key events. The scanner supplies a flag that is high while any key is down, the code of the key it currently sees, and a scan-rate tick. The block turns this into a clean event stream. On each physical press it raises a one-cycle `key_strobe` and latches the key's code on `key_value`. Nothing else is registered until every key has been let go.

Contact bounce is filtered by the state sequence rather than by a filter on each button. A press counts only after the flag has been seen high on `SETTLE_TICKS` consecutive ticks. A release counts only after the flag has been seen low on the same number of consecutive ticks. A press seen during the release window returns the machine to the held state, and no new event is issued. The flag and the code are only looked at on tick cycles. Both outputs come straight from flops.

Top module: `keyreg_oneshot`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `key_strobe` is 0 and `key_value` is 0.
- R2: From idle, when `key_any` is 1 on `SETTLE_TICKS` consecutive cycles where `scan_tick` is 1 (default 2), `key_strobe` is 1 in the cycle after the last of those tick cycles. In that same cycle `key_value` equals the `key_code` that was present on that last tick.
- R3: `key_strobe` is never 1 on two consecutive cycles.
- R4: After a registration, no further `key_strobe` occurs until a release has been confirmed, whatever `key_code` does.
- R5: A release is confirmed only after `key_any` is 0 on `SETTLE_TICKS` consecutive tick cycles. A tick with `key_any` at 1 inside that window returns the block to the held state, with no strobe.
- R6: During press confirmation, a tick with `key_any` at 0 discards the partial count. A later strobe then again needs `SETTLE_TICKS` consecutive high ticks.
- R7: `key_value` changes only in a cycle in which `key_strobe` is 1, and otherwise holds the last registered code.
- R8: The values of `key_any` and `key_code` on cycles where `scan_tick` is 0 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle enable, once per scan period |
| key_any | input | 1 | High while the scanner sees any key down |
| key_code | input | CODE_W | Code of the key currently seen by the scanner |
| key_strobe | output | 1 | One-cycle pulse per registered press |
| key_value | output | CODE_W | Code of the most recently registered key |

## Verification
The bench runs every 8-tick pattern of the press flag, with the code changing on every tick. This covers single-tick glitches during press confirmation, a press seen during the release window, and holds of every length. A design that forgot to clear its run count would register a bounced press early. A design that released after one low tick would emit a second event for a single press. Between ticks, the bench drives the opposite flag level and a different code. A block that sampled off-tick would then strobe, or would latch the wrong code. After each event, `key_value` is compared against the code from the confirming tick, which catches a block that captured on the first detection or on a later tick.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;

  typedef enum logic [1:0] {
    KR_IDLE            = 2'd0,
    KR_PRESS_CONFIRM   = 2'd1,
    KR_HELD            = 2'd2,
    KR_RELEASE_CONFIRM = 2'd3
  } kr_state_e;

  // Pressing phase looks for the flag high, releasing phase looks for it low.
  function automatic logic kr_pressing_phase(input kr_state_e st);
    return (st == KR_IDLE) || (st == KR_PRESS_CONFIRM);
  endfunction

  function automatic logic kr_level_wanted(input kr_state_e st, input logic any_down);
    return kr_pressing_phase(st) ? any_down : !any_down;
  endfunction

  // True when one more qualifying tick completes a run of 'limit' ticks.
  function automatic logic kr_run_complete(input int count, input int limit);
    return (count + 1) >= limit;
  endfunction

endpackage

// File: rtl/keyreg_run_counter.sv
module keyreg_run_counter #(
  parameter int LIMIT = 2,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level_ok,
  input  logic confirm,
  output logic run_done
);
  import keyreg_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  assign run_done = tick && level_ok && kr_run_complete(int'(cnt_q), LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (confirm) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (!level_ok)
        cnt_q <= '0;
      else if (int'(cnt_q) < LIMIT)
        cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/keyreg_fsm.sv
module keyreg_fsm
  import keyreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      any_down,
  input  logic      run_done,
  output kr_state_e state_q,
  output logic      level_ok,
  output logic      press_confirm,
  output logic      release_confirm
);

  kr_state_e state_d;

  assign level_ok        = kr_level_wanted(state_q, any_down);
  assign press_confirm   = run_done && kr_pressing_phase(state_q);
  assign release_confirm = run_done && !kr_pressing_phase(state_q);

  always_comb begin
    state_d = state_q;
    if (tick) begin
      unique case (state_q)
        KR_IDLE:
          if (any_down) state_d = run_done ? KR_HELD : KR_PRESS_CONFIRM;
        KR_PRESS_CONFIRM:
          if (!any_down)    state_d = KR_IDLE;
          else if (run_done) state_d = KR_HELD;
        KR_HELD:
          if (!any_down) state_d = run_done ? KR_IDLE : KR_RELEASE_CONFIRM;
        KR_RELEASE_CONFIRM:
          if (any_down)      state_d = KR_HELD;
          else if (run_done) state_d = KR_IDLE;
        default: state_d = KR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KR_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/keyreg_capture.sv
module keyreg_capture #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] code_in,
  output logic              strobe_q,
  output logic [CODE_W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      code_q   <= '0;
    end else begin
      strobe_q <= take;
      if (take) code_q <= code_in;
    end
  end

endmodule

// File: rtl/keyreg_oneshot.sv
module keyreg_oneshot #(
  parameter int CODE_W       = 4,
  parameter int SETTLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_tick,
  input  logic              key_any,
  input  logic [CODE_W-1:0] key_code,
  output logic              key_strobe,
  output logic [CODE_W-1:0] key_value
);
  import keyreg_pkg::*;

  kr_state_e state_q;
  logic      level_ok;
  logic      run_done;
  logic      press_confirm;
  logic      release_confirm;
  logic      any_confirm;

  assign any_confirm = press_confirm || release_confirm;

  keyreg_run_counter #(.LIMIT(SETTLE_TICKS)) run_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (scan_tick),
    .level_ok (level_ok),
    .confirm  (any_confirm),
    .run_done (run_done)
  );

  keyreg_fsm fsm_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick            (scan_tick),
    .any_down        (key_any),
    .run_done        (run_done),
    .state_q         (state_q),
    .level_ok        (level_ok),
    .press_confirm   (press_confirm),
    .release_confirm (release_confirm)
  );

  keyreg_capture #(.CODE_W(CODE_W)) cap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (press_confirm),
    .code_in  (key_code),
    .strobe_q (key_strobe),
    .code_q   (key_value)
  );

endmodule

// File: rtl/keyreg_oneshot_chk.sv
module keyreg_oneshot_chk
  import keyreg_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_tick,
  input logic              key_any,
  input logic [CODE_W-1:0] key_code,
  input logic              key_strobe,
  input logic [CODE_W-1:0] key_value,
  input kr_state_e         state_q,
  input logic              release_confirm
);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    key_strobe |=> !key_strobe);

  a_r7_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !key_strobe |-> $stable(key_value));

  a_r8_no_tick_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> !key_strobe);

  a_r2_event_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
    key_strobe |-> ($past(scan_tick) && $past(key_any)));

  a_r2_code_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    key_strobe |-> (key_value == $past(key_code)));

  a_r4_held_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KR_HELD) |=> !key_strobe);

  a_r5_bounce_back: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KR_RELEASE_CONFIRM && scan_tick && key_any) |=> (state_q == KR_HELD));

  a_r5_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    release_confirm |-> (scan_tick && !key_any));

endmodule

bind keyreg_oneshot keyreg_oneshot_chk #(.CODE_W(CODE_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .scan_tick       (scan_tick),
  .key_any         (key_any),
  .key_code        (key_code),
  .key_strobe      (key_strobe),
  .key_value       (key_value),
  .state_q         (state_q),
  .release_confirm (release_confirm)
);

// File: tb/keyreg_oneshot_tb_top.sv
module keyreg_oneshot_tb_top;
  localparam int CW = 4;
  localparam int N  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scan_tick;
  logic          key_any;
  logic [CW-1:0] key_code;
  logic          key_strobe;
  logic [CW-1:0] key_value;

  int n_checks = 0;
  int n_fail   = 0;

  // bench reference state
  bit            m_held = 0;
  int            m_run  = 0;
  logic [CW-1:0] m_code = '0;

  always #5 clk = ~clk;

  keyreg_oneshot #(.CODE_W(CW), .SETTLE_TICKS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .key_any(key_any),
    .key_code(key_code), .key_strobe(key_strobe), .key_value(key_value)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, step one rising edge, sample at the next falling edge.
  task automatic step(input bit ti, input bit a, input logic [CW-1:0] c);
    bit    exp_pulse;
    string tag;
    scan_tick = ti; key_any = a; key_code = c;
    exp_pulse = 0;
    tag = "R8";
    if (ti) begin
      if (!m_held) begin
        tag = "R6";
        if (a) begin
          m_run++;
          if (m_run >= N) begin exp_pulse = 1; m_code = c; m_held = 1; m_run = 0; tag = "R2"; end
        end else m_run = 0;
      end else begin
        tag = "R4";
        if (!a) begin
          m_run++;
          if (m_run >= N) begin m_held = 0; m_run = 0; tag = "R5"; end
        end else begin
          m_run = 0; tag = "R5";
        end
      end
    end
    @(negedge clk);
    check(key_strobe == exp_pulse, tag, key_strobe, exp_pulse);
    check(key_value == m_code, exp_pulse ? "R2" : "R7", key_value, m_code);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; scan_tick = 1'b0; key_any = 1'b1; key_code = 4'hF;
    repeat (3) @(negedge clk);
    check(key_strobe == 1'b0, "R1", key_strobe, 0);
    check(key_value == '0, "R1", key_value, 0);
    rst_n = 1'b1; key_any = 1'b0;
    @(negedge clk);
    check(key_strobe == 1'b0, "R1", key_strobe, 0);
    check(key_value == '0, "R1", key_value, 0);

    // Directed R2/R3: clean press of key 5, then one idle cycle.
    step(1, 1, 4'h3);
    step(1, 1, 4'h5);
    step(0, 1, 4'h5);   // R3: strobe already gone
    // Directed R5: release bounce must not re-register.
    step(1, 0, 4'h0);
    step(1, 1, 4'h9);
    step(1, 0, 4'h0);
    step(1, 1, 4'hA);
    step(1, 1, 4'hB);   // R4: still held
    step(1, 0, 4'h0);
    step(1, 0, 4'h0);   // release confirmed
    // Directed R6: glitch during press confirm.
    step(1, 1, 4'h1);
    step(1, 0, 4'h1);
    step(1, 1, 4'h2);
    step(1, 1, 4'h7);   // R2 with code 7
    step(1, 0, 4'h0);
    step(1, 0, 4'h0);

    // Sweep every 8-tick flag pattern; off-tick cycles drive the opposite level.
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < 8; i++) begin
        step(1, p[i], CW'((p + i) % 16));
        step(0, !p[i], CW'((p * 7 + i + 3) % 16));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule